// File: doc/BRIEF.md
# Master and Processor Clock Controller

This block derives a processor clock, a master clock and a set of gated peripheral clocks from one of four source clocks: slow, main oscillator, PLL A or PLL B. The source clocks arrive as level waveforms and are sampled by a fast block clock `clk`, so the controller runs entirely in one synchronous domain. A 3-bit prescaler divides the chosen source by a power of two up to 64 to form the processor clock. A 2-bit master divider then divides that result again to form the master clock, so the processor can run at a multiple of the bus rate.

Software drives the block through a small word-addressed register port. A configuration write starts a switch sequence. First the master clock is allowed to fall twice on the old settings and the root is parked low. Then the block waits for two falling edges of the new source, counted only while that source reports ready or locked. The new settings take over on a low phase, which keeps every output pulse whole. A ready flag is low for the whole sequence. The processor clock can be parked for wait-for-interrupt idle while the master clock keeps running. It restarts when an interrupt request is pending. Peripheral clocks for IDs 2 and up are set and cleared one bit at a time.

Top module: `mclk_ctrl`

## Requirements
- R1: After reset the source is slow (code 0), both dividers are /1, the ready flag is 1, the processor clock is enabled and the peripheral enable mask reads 0.
- R2: Config bits [1:0] select the source (0 slow, 1 main oscillator, 2 PLL A, 3 PLL B). Once ready returns, mck_o follows the chosen source.
- R3: Config bits [4:2] set the prescaler. Codes 0 to 6 divide by 2^code, and code 7 divides by 64. The processor clock period equals the source period times that factor.
- R4: Config bits [6:5] set the master divider m. The mck_o period is 2^m times the pck_o period.
- R5: Status bit 0 (ready) reads 0 in the cycle after an accepted config write and returns to 1 when the switch completes. A config write made while ready is 0 is ignored. The config register reads back the last accepted value.
- R6: A switch waits for two falling edges of mck_o and then for two falling edges of the new source. No high or low phase of mck_o is shorter than two block-clock cycles when every source half period is at least two cycles.
- R7: A switch to the main oscillator or to a PLL does not complete while that source's ready or lock input is low, and mck_o stays low meanwhile. Status bits 1, 2 and 3 show the main-ready, PLL A lock and PLL B lock inputs.
- R8: Writing 1 to bit 0 of the system-clear register (0x1) stops pck_o while mck_o keeps running. The system status register (0x2) bit 0 then reads 0.
- R9: A high irq_i, or a write of 1 to bit 0 of the system-set register (0x0), re-enables pck_o.
- R10: The peripheral set (0x4) and clear (0x5) registers are write-1-to-set and write-1-to-clear. The peripheral status register (0x6) returns the mask. pclk_o[i] follows mck_o while bit i is set and is held low otherwise.
- R11: Peripheral bits 0 and 1 cannot be set, and pclk_o[1:0] stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the sources |
| rst_n | input | 1 | Active-low reset |
| src_clk_i | input | 4 | Source clock levels: [0] slow, [1] main, [2] PLL A, [3] PLL B |
| mosc_rdy_i | input | 1 | Main oscillator stable |
| plla_lock_i | input | 1 | PLL A locked |
| pllb_lock_i | input | 1 | PLL B locked |
| irq_i | input | 1 | Pending interrupt request, wakes the processor clock |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| pck_o | output | 1 | Processor clock |
| mck_o | output | 1 | Master clock |
| pclk_o | output | 32 | Gated peripheral clocks |

## Verification
The minimum-width properties on mck_o assume that every source toggles no faster than once per two block-clock cycles. The bench keeps to this by running the four sources with periods of 16, 10, 4 and 6 block-clock cycles and never aligning them with a block-clock edge. The properties also assume that the active source never stops mid-switch. The bench therefore only drops a lock input on a source that is not selected, and raises it to release a pending switch. Config writes are made from a negedge-driven task, so a write and the read of the ready flag that follows never share an edge.

// File: rtl/mclk_ctrl_pkg.sv
package mclk_ctrl_pkg;
   localparam int NSRC   = 4;
   localparam int SEL_W  = 2;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int PRES_W = 3;
   localparam int MDIV_W = 2;

   typedef struct packed {
      logic [MDIV_W-1:0] mdiv;
      logic [PRES_W-1:0] pres;
      logic [SEL_W-1:0]  src;
   } mcfg_t;

   localparam int MCFG_W = $bits(mcfg_t);

   typedef enum logic [1:0] {SW_IDLE, SW_DRAIN, SW_FILL} sw_state_e;

   localparam logic [ADDR_W-1:0] A_SYS_SET  = 4'h0;
   localparam logic [ADDR_W-1:0] A_SYS_CLR  = 4'h1;
   localparam logic [ADDR_W-1:0] A_SYS_STAT = 4'h2;
   localparam logic [ADDR_W-1:0] A_PER_SET  = 4'h4;
   localparam logic [ADDR_W-1:0] A_PER_CLR  = 4'h5;
   localparam logic [ADDR_W-1:0] A_PER_STAT = 4'h6;
   localparam logic [ADDR_W-1:0] A_MCFG     = 4'h8;
   localparam logic [ADDR_W-1:0] A_STATUS   = 4'h9;
endpackage

// File: rtl/mclk_pow2_div.sv
module mclk_pow2_div #(
   parameter int LOG_MAX = 6,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_lvl,
   input  logic [SEL_W-1:0] sel,
   output logic             out_lvl
);
   localparam int CNT_W = LOG_MAX;

   generate
      if (LOG_MAX < 1) begin : g_bad
         $error("mclk_pow2_div: LOG_MAX must be at least 1");
      end
   endgenerate

   logic             prev;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   int               eff;

   // codes above LOG_MAX saturate at the largest ratio
   always_comb begin
      eff = (int'(sel) > LOG_MAX) ? LOG_MAX : int'(sel);
      mask = '0;
      for (int k = 0; k < CNT_W; k++) begin
         if (k < eff) mask[k] = 1'b1;
      end
      out_lvl = in_lvl;
      for (int k = 1; k <= CNT_W; k++) begin
         if (eff == k) out_lvl = cnt[k-1];
      end
   end

   // count falling input edges; the count wraps at the selected modulus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         cnt  <= '0;
      end else begin
         prev <= in_lvl;
         if (prev && !in_lvl) cnt <= (cnt + 1'b1) & mask;
      end
   end
endmodule

// File: rtl/mclk_clk_gate.sv
module mclk_clk_gate #(
   parameter bit RST_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_lvl,
   input  logic en_req,
   output logic gclk
);
   logic on;

   // the enable only moves while the gated clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        on <= RST_ON;
      else if (!clk_lvl) on <= en_req;
   end

   assign gclk = clk_lvl & on;
endmodule

// File: rtl/mclk_src_switch.sv
module mclk_src_switch
   import mclk_ctrl_pkg::*;
#(
   parameter int EDGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             old_fall,
   input  logic [NSRC-1:0]  src_fall,
   input  logic [NSRC-1:0]  src_ok,
   output logic [SEL_W-1:0] sel,
   output logic             root_en,
   output logic             busy,
   output logic             done
);
   localparam int CW = $clog2(EDGES + 1);

   generate
      if (EDGES < 1) begin : g_bad
         $error("mclk_src_switch: EDGES must be at least 1");
      end
   endgenerate

   sw_state_e        st;
   logic [CW-1:0]    cnt;
   logic [SEL_W-1:0] nsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SW_IDLE;
         cnt     <= '0;
         sel     <= '0;
         nsel    <= '0;
         root_en <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            SW_IDLE: begin
               if (req) begin
                  nsel <= req_sel;
                  cnt  <= '0;
                  st   <= SW_DRAIN;
               end
            end
            SW_DRAIN: begin
               if (old_fall) begin
                  if (cnt == CW'(EDGES - 1)) begin
                     root_en <= 1'b0;
                     cnt     <= '0;
                     st      <= SW_FILL;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            SW_FILL: begin
               if (src_fall[nsel] && src_ok[nsel]) begin
                  if (cnt == CW'(EDGES - 1)) begin
                     sel     <= nsel;
                     root_en <= 1'b1;
                     done    <= 1'b1;
                     st      <= SW_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: st <= SW_IDLE;
         endcase
      end
   end

   assign busy = (st != SW_IDLE);
endmodule

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
   import mclk_ctrl_pkg::*;
#(
   parameter int NPER        = 32,
   parameter int FIRST_PER   = 2,
   parameter int PRES_MAX    = 6,
   parameter int MDIV_MAX    = 3,
   parameter int DRAIN_EDGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        src_clk_i,
   input  logic              mosc_rdy_i,
   input  logic              plla_lock_i,
   input  logic              pllb_lock_i,
   input  logic              irq_i,
   input  logic              reg_wr_i,
   input  logic [3:0]        reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              pck_o,
   output logic              mck_o,
   output logic [NPER-1:0]   pclk_o
);
   localparam logic [NPER-1:0] PER_VALID = {NPER{1'b1}} << FIRST_PER;

   generate
      if (NPER > DATA_W || NPER < 1) begin : g_bad_nper
         $error("mclk_ctrl: NPER must be 1..32");
      end
      if (FIRST_PER >= NPER) begin : g_bad_first
         $error("mclk_ctrl: FIRST_PER must be below NPER");
      end
      if (PRES_MAX < 1 || MDIV_MAX < 1) begin : g_bad_div
         $error("mclk_ctrl: divider limits must be positive");
      end
   endgenerate

   // source sampling and edge detection
   logic [NSRC-1:0] s1, s2, src_fall, src_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= '0;
         s2 <= '0;
      end else begin
         s1 <= src_clk_i;
         s2 <= s1;
      end
   end
   assign src_fall = s2 & ~s1;
   assign src_ok   = {pllb_lock_i, plla_lock_i, mosc_rdy_i, 1'b1};

   // register decode
   logic wr_sys_set, wr_sys_clr, wr_per_set, wr_per_clr, wr_mcfg;
   assign wr_sys_set = reg_wr_i && (reg_addr_i == A_SYS_SET);
   assign wr_sys_clr = reg_wr_i && (reg_addr_i == A_SYS_CLR);
   assign wr_per_set = reg_wr_i && (reg_addr_i == A_PER_SET);
   assign wr_per_clr = reg_wr_i && (reg_addr_i == A_PER_CLR);
   assign wr_mcfg    = reg_wr_i && (reg_addr_i == A_MCFG);

   // source switch
   logic             busy, done, root_en, mck_prev, mck_fall, req;
   logic [SEL_W-1:0] sel;
   mcfg_t            cfg_pend, cfg_act;

   assign req = wr_mcfg && !busy;

   mclk_src_switch #(.EDGES(DRAIN_EDGES)) u_sw (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_sel  (reg_wdata_i[SEL_W-1:0]),
      .old_fall (mck_fall),
      .src_fall (src_fall),
      .src_ok   (src_ok),
      .sel      (sel),
      .root_en  (root_en),
      .busy     (busy),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_pend <= '0;
         cfg_act  <= '0;
      end else begin
         if (req)  cfg_pend <= mcfg_t'(reg_wdata_i[MCFG_W-1:0]);
         if (done) cfg_act  <= cfg_pend;
      end
   end

   // divider chain
   logic root_lvl, pres_lvl, mck_lvl;
   assign root_lvl = root_en & s1[sel];

   mclk_pow2_div #(.LOG_MAX(PRES_MAX), .SEL_W(PRES_W)) u_pres (
      .clk(clk), .rst_n(rst_n), .in_lvl(root_lvl), .sel(cfg_act.pres), .out_lvl(pres_lvl)
   );
   mclk_pow2_div #(.LOG_MAX(MDIV_MAX), .SEL_W(MDIV_W)) u_mdiv (
      .clk(clk), .rst_n(rst_n), .in_lvl(pres_lvl), .sel(cfg_act.mdiv), .out_lvl(mck_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mck_prev <= 1'b0;
      else        mck_prev <= mck_lvl;
   end
   assign mck_fall = mck_prev & ~mck_lvl;
   assign mck_o    = mck_lvl;

   // processor clock idle control: wake has priority over stop
   logic pck_req;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   pck_req <= 1'b1;
      else if (irq_i || (wr_sys_set && reg_wdata_i[0])) pck_req <= 1'b1;
      else if (wr_sys_clr && reg_wdata_i[0])        pck_req <= 1'b0;
   end

   mclk_clk_gate #(.RST_ON(1'b1)) u_pck_gate (
      .clk(clk), .rst_n(rst_n), .clk_lvl(pres_lvl), .en_req(pck_req), .gclk(pck_o)
   );

   // peripheral enables
   logic [NPER-1:0] per_en;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_en <= '0;
      end else if (wr_per_set) begin
         per_en <= (per_en | reg_wdata_i[NPER-1:0]) & PER_VALID;
      end else if (wr_per_clr) begin
         per_en <= per_en & ~reg_wdata_i[NPER-1:0] & PER_VALID;
      end
   end

   generate
      for (genvar g = 0; g < NPER; g++) begin : g_per
         if (g >= FIRST_PER) begin : g_gate
            mclk_clk_gate #(.RST_ON(1'b0)) u_gate (
               .clk(clk), .rst_n(rst_n), .clk_lvl(mck_lvl), .en_req(per_en[g]), .gclk(pclk_o[g])
            );
         end else begin : g_off
            assign pclk_o[g] = 1'b0;
         end
      end
   endgenerate

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_SYS_STAT: reg_rdata_o[0]            = pck_req;
         A_PER_STAT: reg_rdata_o[NPER-1:0]     = per_en;
         A_MCFG:     reg_rdata_o[MCFG_W-1:0]   = cfg_pend;
         A_STATUS:   reg_rdata_o[3:0]          = {pllb_lock_i, plla_lock_i, mosc_rdy_i, ~busy};
         default:    reg_rdata_o               = '0;
      endcase
   end
endmodule

// File: rtl/mclk_ctrl_chk.sv
module mclk_ctrl_chk
   import mclk_ctrl_pkg::*;
#(
   parameter int NPER      = 32,
   parameter int FIRST_PER = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr_i,
   input logic [3:0]      reg_addr_i,
   input logic            irq_i,
   input logic            busy,
   input logic            pck_req,
   input logic            pck_o,
   input logic            mck_o,
   input logic [NPER-1:0] pclk_o
);
   localparam logic [NPER-1:0] PER_VALID = {NPER{1'b1}} << FIRST_PER;

   // R5: an accepted config write drops ready on the next cycle
   a_r5_rdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_MCFG && !busy) |=> busy);

   // R6: master clock phases last at least two block cycles
   a_r6_high_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mck_o) |=> mck_o);
   a_r6_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mck_o) |=> !mck_o);

   // R8: a parked processor clock stays parked while no wake request exists
   a_r8_pck_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (!pck_req && !pck_o) |=> !pck_o);

   // R9: a pending interrupt raises the wake request
   a_r9_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> pck_req);

   // R10: a peripheral clock is never high while the master clock is low
   a_r10_pclk_in_mck: assert property (@(posedge clk) disable iff (!rst_n)
      ((pclk_o & ~{NPER{mck_o}}) == '0));

   // R11: reserved peripheral IDs never clock
   a_r11_low_ids: assert property (@(posedge clk) disable iff (!rst_n)
      ((pclk_o & ~PER_VALID) == '0));
endmodule

bind mclk_ctrl mclk_ctrl_chk #(.NPER(NPER), .FIRST_PER(FIRST_PER)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr_i   (reg_wr_i),
   .reg_addr_i (reg_addr_i),
   .irq_i      (irq_i),
   .busy       (busy),
   .pck_req    (pck_req),
   .pck_o      (pck_o),
   .mck_o      (mck_o),
   .pclk_o     (pclk_o)
);

// File: tb/mclk_ctrl_tb.sv
`timescale 1ns/100ps
module mclk_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_slow = 1'b0, s_main = 1'b0, s_plla = 1'b0, s_pllb = 1'b0;
   logic        mosc_rdy = 1'b1, plla_lock = 1'b0, pllb_lock = 1'b1;
   logic        irq = 1'b0, wr = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = '0, rdata;
   logic        pck, mck;
   logic [31:0] pclk;

   int checks = 0, fails = 0, min_run = 1000;

   always #2.5 clk = ~clk;
   initial begin #1; forever #40 s_slow = ~s_slow; end  // 16 cycles
   initial begin #1; forever #25 s_main = ~s_main; end  // 10 cycles
   initial begin #1; forever #10 s_plla = ~s_plla; end  // 4 cycles
   initial begin #1; forever #15 s_pllb = ~s_pllb; end  // 6 cycles

   mclk_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_clk_i({s_pllb, s_plla, s_main, s_slow}),
      .mosc_rdy_i(mosc_rdy), .plla_lock_i(plla_lock), .pllb_lock_i(pllb_lock),
      .irq_i(irq), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .pck_o(pck), .mck_o(mck), .pclk_o(pclk)
   );

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   // R6 phase-width monitor on mck
   logic mlast = 1'b0; int mrun = 0; bit mseen = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mck === mlast) mrun++;
         else begin
            if (mseen && mrun < min_run) min_run = mrun;
            mseen = 1; mrun = 1; mlast = mck;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output int d);
      @(negedge clk); addr = a; #1; d = int'(rdata);
   endtask

   function automatic logic sig(input int w);
      if (w == 0) return mck;
      if (w == 1) return pck;
      return pclk[w-100];
   endfunction

   task automatic meas(input int w, output int per);
      logic p, c; int t0 = -1;
      per = -1;
      @(negedge clk); p = sig(w);
      for (int i = 0; i < 6000 && per < 0; i++) begin
         @(negedge clk); c = sig(w);
         if (!p && c) begin
            if (t0 < 0) t0 = i; else per = i - t0;
         end
         p = c;
      end
   endtask

   task automatic rises(input int w, input int n, output int cnt);
      logic p, c;
      cnt = 0;
      @(negedge clk); p = sig(w);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); c = sig(w);
         if (!p && c) cnt++;
         p = c;
      end
   endtask

   task automatic wait_rdy();
      int d = 0;
      for (int i = 0; i < 20000; i++) begin
         rd_reg(4'h9, d);
         if (d[0]) break;
      end
   endtask

   task automatic t_reset();
      int d, per;
      rd_reg(4'h9, d); chk("R1 status ready, main ok, PLL B lock", d, 32'hB);
      rd_reg(4'h2, d); chk("R1 processor clock enabled", d, 1);
      rd_reg(4'h6, d); chk("R1 peripheral mask empty", d, 0);
      rd_reg(4'h8, d); chk("R1 config zero", d, 0);
      meas(0, per);    chk("R1 mck period from slow", per, 16);
      meas(1, per);    chk("R1 pck period from slow", per, 16);
   endtask

   task automatic t_main();
      int d, per;
      wr_reg(4'h8, 32'h01);
      #1; addr = 4'h9; #1; chk("R5 ready low after config write", int'(rdata[0]), 0);
      wait_rdy();
      meas(0, per); chk("R2 mck period from main", per, 10);
   endtask

   task automatic t_plla_lock();
      int d, per, n;
      wr_reg(4'h8, 32'h02);
      wr_reg(4'h8, 32'h03);            // ignored: switch in progress
      repeat (300) @(negedge clk);
      rd_reg(4'h9, d); chk("R7 switch held while PLL A unlocked", d, 32'hA);
      rises(0, 100, n); chk("R7 mck parked low while waiting for lock", n, 0);
      @(negedge clk); plla_lock = 1'b1;
      wait_rdy();
      rd_reg(4'h8, d); chk("R5 write during switch ignored", d, 2);
      rd_reg(4'h9, d); chk("R7 status shows all lock bits", d, 32'hF);
      meas(0, per);    chk("R2 mck period from PLL A", per, 4);
   endtask

   task automatic t_div();
      int per;
      wr_reg(4'h8, 32'h2F);            // PLL B, prescale /8, master /2
      wait_rdy();
      meas(1, per); chk("R3 pck period PLL B /8", per, 48);
      meas(0, per); chk("R4 mck period twice pck", per, 96);
   endtask

   task automatic t_pres_max();
      int per;
      wr_reg(4'h8, 32'h1D);            // main, prescale code 7, master /1
      wait_rdy();
      meas(1, per); chk("R3 prescale code 7 divides by 64", per, 640);
      meas(0, per); chk("R4 master /1 equals pck", per, 640);
   endtask

   task automatic t_idle();
      int d, per, n;
      wr_reg(4'h8, 32'h22);            // PLL A, /1, master /2
      wait_rdy();
      meas(1, per); chk("R4 pck period PLL A", per, 4);
      wr_reg(4'h1, 32'h1);
      repeat (10) @(negedge clk);
      rises(1, 100, n); chk("R8 pck stopped after system clear", n, 0);
      meas(0, per);     chk("R8 mck keeps running in idle", per, 8);
      rd_reg(4'h2, d);  chk("R8 system status shows stopped", d, 0);
      @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
      meas(1, per);     chk("R9 irq restarts pck", per, 4);
      rd_reg(4'h2, d);  chk("R9 system status after wake", d, 1);
      wr_reg(4'h1, 32'h1);
      repeat (10) @(negedge clk);
      rises(1, 50, n);  chk("R8 pck stopped again", n, 0);
      wr_reg(4'h0, 32'h1);
      meas(1, per);     chk("R9 system set restarts pck", per, 4);
   endtask

   task automatic t_periph();
      int d, per, n;
      wr_reg(4'h4, 32'hF);
      rd_reg(4'h6, d);  chk("R11 bits 0 and 1 not settable", d, 32'hC);
      meas(102, per);   chk("R10 pclk[2] follows mck", per, 8);
      rises(100, 60, n); chk("R11 pclk[0] stays low", n, 0);
      rises(101, 60, n); chk("R11 pclk[1] stays low", n, 0);
      rises(104, 60, n); chk("R10 pclk[4] off when not set", n, 0);
      wr_reg(4'h5, 32'h4);
      rd_reg(4'h6, d);  chk("R10 write-1-to-clear leaves bit 3", d, 32'h8);
      repeat (10) @(negedge clk);
      rises(102, 60, n); chk("R10 pclk[2] stopped after clear", n, 0);
      meas(103, per);   chk("R10 pclk[3] still running", per, 8);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_main();
      t_plla_lock();
      t_div();
      t_pres_max();
      t_idle();
      t_periph();
      chk("R6 shortest mck phase at least 2 cycles", (min_run >= 2) ? 1 : 0, 1);
      summary();
      $finish;
   end
endmodule